// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block sits between the clock synthesizers of a system clock generator and the output drivers. It receives one running source clock per output group and decides, from three active-low power-management inputs, which groups may pass their clock on. The inputs are a CPU-domain stop, a PCI-domain stop and a power-down request. A stopped group is held at a steady LOW. Stopping and restarting never shorten a high phase.

The controller runs on the free-running PCI-rate clock. It synchronizes the three requests in that clock's domain and turns them into one registered enable per group. Each enable is handed to its group through a gate that only changes state while the group's source clock is LOW. A power-down request stops every group, then drops the oscillator/VCO enable. When the request is withdrawn, the oscillator enable returns at once. The outputs stay LOW for a programmable settling count, which stands in for the power-up wait.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is LOW (synchronous: sampled by the reference clock and by each source clock's falling edge), every clock output and `osc_en_o` are LOW. After release with `pwr_dn_n_i` HIGH, `osc_en_o` rises at the third rising reference edge that samples `rst_n` HIGH.
- R2: With `cpu_stop_n_i` LOW, the CPU group and the fixed 66 MHz group are held LOW. The half-rate, APIC, REF, USB and all PCI groups keep running.
- R3: With `pci_stop_n_i` LOW, the seven stoppable PCI lines are held LOW. `pci_free_o` keeps toggling, as do all non-PCI groups.
- R4: With `pwr_dn_n_i` LOW, every output is held LOW, including REF, USB and `pci_free_o`. Counting from the third rising reference edge that samples the request LOW, the group enables drop at that edge and `osc_en_o` drops one edge later.
- R5: Each request passes two synchronizer flops clocked by the reference clock, then one enable register. A change sampled at reference edge k takes effect at edge k+2. Affected outputs follow within one source period of that edge and are unchanged before it.
- R6: On leaving power down, `osc_en_o` rises at the third rising reference edge that samples `pwr_dn_n_i` HIGH. All outputs stay LOW for `WAKE_CYCLES` further reference edges, then start.
- R7: Every HIGH pulse on a gated output lasts a full HIGH phase of its source clock. A stopped output rests LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci_free_i | input | 1 | Free-running PCI-rate reference clock; clocks the controller and feeds `pci_free_o` |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_stop_n_i | input | 1 | Asynchronous CPU-domain stop request, active LOW |
| pci_stop_n_i | input | 1 | Asynchronous PCI-domain stop request, active LOW |
| pwr_dn_n_i | input | 1 | Asynchronous power-down request, active LOW |
| cpu_src_i | input | 1 | CPU-rate source clock |
| half_src_i | input | 1 | Half-CPU-rate source clock |
| fix66_src_i | input | 1 | Fixed 66 MHz source clock |
| apic_src_i | input | 1 | APIC-rate source clock |
| ref_src_i | input | 1 | Crystal-rate reference source clock |
| usb_src_i | input | 1 | 48 MHz source clock |
| pci_src_i | input | 1 | PCI-rate source for the stoppable PCI lines |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| half_clk_o | output | N_HALF | Gated half-rate clocks |
| fix66_clk_o | output | N_66 | Gated fixed 66 MHz clocks |
| apic_clk_o | output | N_APIC | Gated APIC clocks |
| ref_clk_o | output | N_REF | Gated reference clocks |
| usb_clk_o | output | 1 | Gated 48 MHz clock |
| pci_clk_o | output | N_PCI | Stoppable PCI clocks |
| pci_free_o | output | 1 | PCI clock exempt from PCI stop |
| osc_en_o | output | 1 | Oscillator and VCO enable |

## Verification
The hardest case to reach is the exact edge at which a request takes effect. Each group's gate works on its own source clock, so the boundary can only be seen as the presence or absence of output edges in short windows on either side of the third reference edge. The stimulus changes a request 1 ns after a reference edge. It then counts output rising edges in the window up to that third edge, and again from one source period after it. All source clocks are offset from the reference edges, so no window boundary coincides with a source edge. For the wake-up hold, `WAKE_CYCLES` is lowered to 16, so the whole settling interval can be watched edge by edge.

// File: rtl/clkstop_pkg.sv
// Package: group indices, domain masks and controller state encoding shared
// by the clock stop controller, its submodules and its checker.
package clkstop_pkg;

    localparam int NGRP     = 8;
    localparam int GRP_CPU  = 0;
    localparam int GRP_HALF = 1;
    localparam int GRP_66   = 2;
    localparam int GRP_APIC = 3;
    localparam int GRP_REF  = 4;
    localparam int GRP_USB  = 5;
    localparam int GRP_PCI  = 6;
    localparam int GRP_PCIF = 7;

    // Groups silenced by the CPU-domain stop request
    localparam logic [NGRP-1:0] CPU_DOM = NGRP'((1 << GRP_CPU) | (1 << GRP_66));
    // Groups silenced by the PCI-domain stop request (free line exempt)
    localparam logic [NGRP-1:0] PCI_DOM = NGRP'(1 << GRP_PCI);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // oscillator off, all groups LOW
        ST_WAKE  = 2'd1,   // oscillator on, settling count running
        ST_RUN   = 2'd2,   // groups follow stop requests
        ST_DRAIN = 2'd3    // groups stopped, oscillator still on
    } pm_state_t;

endpackage

// File: rtl/clkstop_sync.sv
// Two-flop synchronizer bank for asynchronous control inputs.
// Assumes the inputs are level signals held far longer than one clock period.
// Reset value is 0, which for the active-low requests means "stopped".
module clkstop_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the asynchronous levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/clkstop_seq.sv
// Power-management sequencer in the reference clock domain.
// Takes synchronized run levels and produces one registered enable per group
// plus the oscillator/VCO enable. Power down first drops all enables, then the
// oscillator one edge later. Power up raises the oscillator and holds the
// groups off for WAKE_CYCLES edges. Assumes WAKE_CYCLES >= 3.
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_run_i,
    input  logic            pci_run_i,
    input  logic            pwr_ok_i,
    output logic [NGRP-1:0] grp_en_o,
    output logic            osc_en_o
);

    localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 2;
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    pm_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [NGRP-1:0] stop_mask;
    logic [NGRP-1:0] en_d;
    logic [NGRP-1:0] en_q;

    // Next-state selection for the power sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:   if (!pwr_ok_i) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_OFF;
            ST_OFF:   if (pwr_ok_i) state_d = ST_WAKE;
            ST_WAKE: begin
                if (!pwr_ok_i)              state_d = ST_OFF;
                else if (cnt_q == WAKE_LAST) state_d = ST_RUN;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    // Group enables that the next state and the stop requests allow
    always_comb begin
        stop_mask = (cpu_run_i ? '0 : CPU_DOM) | (pci_run_i ? '0 : PCI_DOM);
        en_d      = (state_d == ST_RUN) ? ~stop_mask : '0;
    end

    // State, settling counter and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            if (state_q == ST_WAKE && state_d == ST_WAKE) cnt_q <= cnt_q + 1'b1;
            else                                          cnt_q <= '0;
        end
    end

    assign grp_en_o = en_q;
    assign osc_en_o = (state_q != ST_OFF);

endmodule

// File: rtl/clkstop_gate.sv
// Glitch-free clock gate for one output group.
// The enable is captured on the source clock's falling edge, so it only
// changes while the source is LOW; the output is the source ANDed with that
// captured enable and therefore never carries a shortened HIGH phase.
// Assumes the source clock toggles during reset so the capture flop clears.
module clkstop_gate (
    input  logic src_i,
    input  logic rst_n,
    input  logic en_i,
    output logic clk_o
);

    logic en_lo_q;

    // Enable capture during the source LOW phase
    always_ff @(negedge src_i) begin
        if (!rst_n) en_lo_q <= 1'b0;
        else        en_lo_q <= en_i;
    end

    assign clk_o = src_i & en_lo_q;

endmodule

// File: rtl/clkstop_ctrl.sv
// Top level of the clock stop controller.
// Synchronizes the three active-low requests, sequences power down and
// wake-up, and gates each output group with its own falling-edge gate.
// Each group drives all of its lines from one gate, so the lines of a group
// start and stop together. Assumes all source clocks run whenever the
// controller is in reset or operating.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int N_HALF      = 2,
    parameter int N_66        = 4,
    parameter int N_APIC      = 3,
    parameter int N_REF       = 2,
    parameter int N_PCI       = 7,
    parameter int WAKE_CYCLES = 100000
) (
    input  logic              clk_pci_free_i,
    input  logic              rst_n,
    input  logic              cpu_stop_n_i,
    input  logic              pci_stop_n_i,
    input  logic              pwr_dn_n_i,
    input  logic              cpu_src_i,
    input  logic              half_src_i,
    input  logic              fix66_src_i,
    input  logic              apic_src_i,
    input  logic              ref_src_i,
    input  logic              usb_src_i,
    input  logic              pci_src_i,
    output logic [N_CPU-1:0]  cpu_clk_o,
    output logic [N_HALF-1:0] half_clk_o,
    output logic [N_66-1:0]   fix66_clk_o,
    output logic [N_APIC-1:0] apic_clk_o,
    output logic [N_REF-1:0]  ref_clk_o,
    output logic              usb_clk_o,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic              pci_free_o,
    output logic              osc_en_o
);

    localparam int NREQ = 3;

    logic [NREQ-1:0] req_sync;
    logic [NGRP-1:0] grp_en;
    logic [NGRP-1:0] grp_src;
    logic [NGRP-1:0] grp_clk;

    clkstop_sync #(.WIDTH(NREQ)) u_sync (
        .clk   (clk_pci_free_i),
        .rst_n (rst_n),
        .d_i   ({pwr_dn_n_i, pci_stop_n_i, cpu_stop_n_i}),
        .q_o   (req_sync)
    );

    clkstop_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
        .clk       (clk_pci_free_i),
        .rst_n     (rst_n),
        .cpu_run_i (req_sync[0]),
        .pci_run_i (req_sync[1]),
        .pwr_ok_i  (req_sync[2]),
        .grp_en_o  (grp_en),
        .osc_en_o  (osc_en_o)
    );

    // Source clock for each group, indexed by the package group numbers
    always_comb begin
        grp_src           = '0;
        grp_src[GRP_CPU]  = cpu_src_i;
        grp_src[GRP_HALF] = half_src_i;
        grp_src[GRP_66]   = fix66_src_i;
        grp_src[GRP_APIC] = apic_src_i;
        grp_src[GRP_REF]  = ref_src_i;
        grp_src[GRP_USB]  = usb_src_i;
        grp_src[GRP_PCI]  = pci_src_i;
        grp_src[GRP_PCIF] = clk_pci_free_i;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        clkstop_gate u_gate (
            .src_i (grp_src[g]),
            .rst_n (rst_n),
            .en_i  (grp_en[g]),
            .clk_o (grp_clk[g])
        );
    end

    assign cpu_clk_o   = {N_CPU{grp_clk[GRP_CPU]}};
    assign half_clk_o  = {N_HALF{grp_clk[GRP_HALF]}};
    assign fix66_clk_o = {N_66{grp_clk[GRP_66]}};
    assign apic_clk_o  = {N_APIC{grp_clk[GRP_APIC]}};
    assign ref_clk_o   = {N_REF{grp_clk[GRP_REF]}};
    assign usb_clk_o   = grp_clk[GRP_USB];
    assign pci_clk_o   = {N_PCI{grp_clk[GRP_PCI]}};
    assign pci_free_o  = grp_clk[GRP_PCIF];

endmodule

// File: rtl/clkstop_chk.sv
// Checker for the clock stop controller: relates the request pins to the
// group enables and the oscillator enable in the reference clock domain.
module clkstop_chk
    import clkstop_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_stop_n,
    input logic            pci_stop_n,
    input logic            pwr_dn_n,
    input logic            osc_en,
    input logic [NGRP-1:0] grp_en
);

    AST_OSC_OFF_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_n && !$past(pwr_dn_n) && !$past(pwr_dn_n, 2) && !$past(pwr_dn_n, 3)
         && !$past(pwr_dn_n, 4)) |-> !osc_en); // R4

    AST_NO_ENABLE_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (grp_en == '0)); // R4

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |=> (grp_en == '0)); // R6

    AST_CPU_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 3))
        |-> (!grp_en[GRP_CPU] && !grp_en[GRP_66])); // R2

    AST_PCI_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_stop_n && !$past(pci_stop_n) && !$past(pci_stop_n, 2) && !$past(pci_stop_n, 3))
        |-> !grp_en[GRP_PCI]); // R3

endmodule

bind clkstop_ctrl clkstop_chk i_chk (
    .clk        (clk_pci_free_i),
    .rst_n      (rst_n),
    .cpu_stop_n (cpu_stop_n_i),
    .pci_stop_n (pci_stop_n_i),
    .pwr_dn_n   (pwr_dn_n_i),
    .osc_en     (osc_en_o),
    .grp_en     (grp_en)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/100ps
// Bench for the clock stop controller: a vector table of stop requests walked
// by one loop, then directed tests for reset, latency edges, power down,
// wake-up hold and pulse integrity. Group bit order in masks:
// 0 CPU, 1 half, 2 66 MHz, 3 APIC, 4 REF, 5 USB, 6 PCI, 7 free PCI.
module test_clkstop_ctrl;

    localparam int WAKE = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic cpu_s = 1'b0, half_s = 1'b0, f66_s = 1'b0, apic_s = 1'b0, ref_s = 1'b0, usb_s = 1'b0;
    logic [3:0] cpu_o, f66_o;
    logic [1:0] half_o, ref_o;
    logic [2:0] apic_o;
    logic [6:0] pci_o;
    logic usb_o, pcif_o, osc_o;
    logic [7:0] obs;

    int n_tests = 0, n_fail = 0, runts = 0;
    int edges [8];
    realtime rise_t [8];
    bit rise_seen [8];
    bit armed = 1'b0;
    real halfp [8] = '{2.5, 5.0, 5.0, 20.0, 7.0, 3.0, 10.0, 10.0};

    always #10 clk = ~clk;
    initial begin #0.3; forever #2.5 cpu_s  = ~cpu_s;  end
    initial begin #0.3; forever #5   half_s = ~half_s; end
    initial begin #0.7; forever #5   f66_s  = ~f66_s;  end
    initial begin #0.3; forever #20  apic_s = ~apic_s; end
    initial begin #0.3; forever #7   ref_s  = ~ref_s;  end
    initial begin #0.3; forever #3   usb_s  = ~usb_s;  end

    clkstop_ctrl #(.WAKE_CYCLES(WAKE)) i_clkstop_ctrl (
        .clk_pci_free_i (clk), .rst_n (rst_n),
        .cpu_stop_n_i (cpu_stop_n), .pci_stop_n_i (pci_stop_n), .pwr_dn_n_i (pwr_dn_n),
        .cpu_src_i (cpu_s), .half_src_i (half_s), .fix66_src_i (f66_s),
        .apic_src_i (apic_s), .ref_src_i (ref_s), .usb_src_i (usb_s), .pci_src_i (clk),
        .cpu_clk_o (cpu_o), .half_clk_o (half_o), .fix66_clk_o (f66_o),
        .apic_clk_o (apic_o), .ref_clk_o (ref_o), .usb_clk_o (usb_o),
        .pci_clk_o (pci_o), .pci_free_o (pcif_o), .osc_en_o (osc_o)
    );

    assign obs = {pcif_o, pci_o[0], usb_o, ref_o[0], apic_o[0], f66_o[0], half_o[0], cpu_o[0]};

    // Edge counting and HIGH-pulse width monitor per group
    for (genvar g = 0; g < 8; g++) begin : g_mon
        always @(posedge obs[g]) begin
            edges[g]++;
            rise_t[g] = $realtime;
            rise_seen[g] = 1'b1;
        end
        always @(negedge obs[g]) begin
            if (armed && rise_seen[g] && ($realtime - rise_t[g] < halfp[g] - 0.05)) runts++;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Running mask over a window of n reference cycles, plus resting levels
    task automatic measure(input int n, output logic [7:0] run, output logic [7:0] lvl);
        int snap [8];
        for (int g = 0; g < 8; g++) snap[g] = edges[g];
        tick(n);
        for (int g = 0; g < 8; g++) run[g] = (edges[g] != snap[g]);
        lvl = obs;
    endtask

    task automatic check_mask(input string req, input logic [7:0] exp);
        logic [7:0] run, lvl;
        measure(10, run, lvl);
        check(req, "running groups", run, exp);
        check(req, "stopped groups rest LOW", lvl & ~run, 8'h00);
    endtask

    // {cpu_stop_n, pci_stop_n, expected running mask}
    localparam logic [9:0] VEC [5] = '{
        {1'b1, 1'b1, 8'hFF},
        {1'b0, 1'b1, 8'hFA},
        {1'b0, 1'b0, 8'hBA},
        {1'b1, 1'b0, 8'hBF},
        {1'b1, 1'b1, 8'hFF}
    };

    initial begin
        int s0;
        logic [7:0] run, lvl;

        // R1: reset state
        tick(6);
        check("R1", "outputs in reset", {31'd0, obs != 8'h00}, 32'd0);
        check("R1", "osc_en in reset", {31'd0, osc_o}, 32'd0);
        rst_n = 1'b1;                      // sampled HIGH at next edge (e1)
        tick(2);
        check("R1", "osc_en at second edge", {31'd0, osc_o}, 32'd0);
        tick(1);
        check("R1", "osc_en at third edge", {31'd0, osc_o}, 32'd1);
        measure(WAKE - 2, run, lvl);
        check("R6", "hold after reset wake", run, 8'h00);
        tick(6);
        armed = 1'b1;
        check_mask("R6", 8'hFF);

        // R2/R3: table of stop requests
        for (int i = 0; i < 5; i++) begin
            cpu_stop_n = VEC[i][9];
            pci_stop_n = VEC[i][8];
            tick(6);
            check_mask(VEC[i][9] ? (VEC[i][8] ? "R2/R3" : "R3") : "R2", VEC[i][7:0]);
        end

        // R5: CPU stop latency, exact edge
        cpu_stop_n = 1'b0;                 // sampled at e1
        tick(2);
        s0 = edges[0];
        @(posedge clk);
        check("R5", "cpu still runs before third edge", {31'd0, edges[0] != s0}, 32'd1);
        #6 s0 = edges[0];
        tick(2);
        check("R5", "cpu stopped after third edge", {31'd0, edges[0] != s0}, 32'd0);
        cpu_stop_n = 1'b1;
        tick(6);

        // R5: PCI start latency, exact edge
        pci_stop_n = 1'b0;
        tick(8);
        pci_stop_n = 1'b1;
        tick(2);
        s0 = edges[6];
        tick(1);
        check("R5", "pci still stopped at third edge", {31'd0, edges[6] != s0}, 32'd0);
        s0 = edges[6];
        tick(2);
        check("R5", "pci running after third edge", {31'd0, edges[6] != s0}, 32'd1);
        tick(4);

        // R4: power down sequence
        pwr_dn_n = 1'b0;
        tick(2);
        check("R4", "osc_en before sync", {31'd0, osc_o}, 32'd1);
        s0 = edges[7];
        tick(1);
        check("R4", "osc_en kept at third edge", {31'd0, osc_o}, 32'd1);
        tick(1);
        check("R4", "osc_en off at fourth edge", {31'd0, osc_o}, 32'd0);
        check_mask("R4", 8'h00);

        // R6: wake-up hold
        pwr_dn_n = 1'b1;
        tick(2);
        check("R6", "osc_en before sync", {31'd0, osc_o}, 32'd0);
        tick(1);
        check("R6", "osc_en on at third edge", {31'd0, osc_o}, 32'd1);
        measure(WAKE - 2, run, lvl);
        check("R6", "all groups held during wait", run, 8'h00);
        tick(6);
        check_mask("R6", 8'hFF);

        // R7: no shortened HIGH pulses across all transitions
        check("R7", "runt pulses", runts, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule